// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This unit runs the entry half of trap handling for a 32-bit core that keeps its handlers in machine mode. Each cycle the pipeline may raise a trap request with an interrupt flag, a cause code and a trap value, together with the PC of the offending instruction. The unit takes the request only when the global interrupt enable is set. It then records the PC, the cause and the trap value. It saves the previous privilege level and the previous enable state into the status fields, clears the enable and switches to machine mode. All of this happens on one clock edge.

On that same edge the unit produces a one-cycle redirect strobe and the handler address. The address is formed from the trap-vector register, which can be in direct or vectored mode. A separate load port lets the return path, which lives elsewhere, restore the enable bit and the privilege level. A trap that is taken in the same cycle wins over that load.

Top module: `mtrap_entry`

## Requirements
- R1: After reset, `saved_pc_o`, `cause_o` and `tval_o` are zero, `gie_o`, `prev_gie_o` and `prev_priv_o` are zero, `priv_o` is 2'b11 (machine) and `redir_o` is low.
- R2: A taken trap sets `cause_o` to the interrupt flag in bit 31, with the 31-bit cause code in bits 30:0.
- R3: A taken trap sets `saved_pc_o` to the `pc_i` value present in the request cycle.
- R4: A taken trap copies the old `priv_o` into `prev_priv_o`, copies the old `gie_o` (which is 1) into `prev_gie_o`, and clears `gie_o`.
- R5: A taken trap sets `tval_o` to `trap_val_i` and sets `priv_o` to 2'b11.
- R6: When `tvec_i[1:0]` is 2'b00, the handler address is `tvec_i` with bits 1:0 forced to zero.
- R7: When `tvec_i[1:0]` is 2'b01 (vectored), the handler address is the masked base plus 4 times the cause code, taken modulo 2^32.
- R8: The `tvec_i[1:0]` values 2'b10 and 2'b11 behave as direct mode.
- R9: A trap request while `gie_o` is 0 changes no state and raises no redirect.
- R10: `redir_o` is high for exactly the one cycle after the edge that takes a trap, with `redir_pc_o` holding the handler address during that cycle.
- R11: When no trap is taken, `ld_i` loads `ld_gie_i` into `gie_o` and `ld_priv_i` into `priv_o` on the next edge. When a trap is taken in the same cycle, the trap updates win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trap_req_i | input | 1 | Trap request for this cycle |
| trap_irq_i | input | 1 | 1 for an interrupt, 0 for an exception |
| trap_code_i | input | 31 | Cause code |
| trap_val_i | input | 32 | Trap value to record |
| pc_i | input | 32 | PC of the trapping instruction |
| tvec_i | input | 32 | Trap-vector register: base in 31:2, mode in 1:0 |
| ld_i | input | 1 | Load enable and privilege from the return path |
| ld_gie_i | input | 1 | Enable value to load |
| ld_priv_i | input | 2 | Privilege value to load |
| saved_pc_o | output | 32 | Saved exception PC |
| cause_o | output | 32 | Recorded cause |
| tval_o | output | 32 | Recorded trap value |
| gie_o | output | 1 | Global interrupt enable |
| prev_gie_o | output | 1 | Enable state before the last trap |
| prev_priv_o | output | 2 | Privilege before the last trap |
| priv_o | output | 2 | Current privilege level |
| redir_o | output | 1 | One-cycle redirect strobe |
| redir_pc_o | output | 32 | Handler address |

## Verification
The assertions assume three things about the inputs. `trap_irq_i` is a plain 0 or 1, every input is known once reset is released, and `tvec_i` is stable in the cycle of a request. The bench drives all inputs on the falling edge, so each value is settled at the rising edge. It holds `trap_req_i` and `ld_i` for exactly one cycle each and never leaves an input undriven. The vector table covers every `tvec_i` mode and both values of the interrupt flag. It also includes two vectored cases whose sum wraps past 2^32.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
    localparam logic [1:0] PRIV_MACH = 2'b11;
    localparam logic [1:0] TVEC_VECT = 2'b01;
endpackage

// File: rtl/mtrap_target.sv
module mtrap_target
    import mtrap_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit VECTORED_EN = 1'b1
) (
    input  logic [XLEN-1:0] tvec_i,
    input  logic [XLEN-2:0] code_i,
    output logic [XLEN-1:0] target_o
);
    localparam int OFS_W = XLEN + 1;

    logic [XLEN-1:0] base;
    assign base = {tvec_i[XLEN-1:2], 2'b00};

    generate
        if (VECTORED_EN) begin : g_vect
            logic [OFS_W-1:0] ofs;
            always_comb begin
                ofs = {code_i, 2'b00};
                if (tvec_i[1:0] == TVEC_VECT) begin
                    target_o = base + ofs[XLEN-1:0];
                end else begin
                    target_o = base;
                end
            end
        end else begin : g_direct
            assign target_o = base;
        end
    endgenerate
endmodule

// File: rtl/mtrap_regs.sv
module mtrap_regs
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            trap_req_i,
    input  logic            trap_irq_i,
    input  logic [XLEN-2:0] trap_code_i,
    input  logic [XLEN-1:0] trap_val_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] target_i,
    input  logic            ld_i,
    input  logic            ld_gie_i,
    input  logic [1:0]      ld_priv_i,
    output logic [XLEN-1:0] saved_pc_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] tval_o,
    output logic            gie_o,
    output logic            prev_gie_o,
    output logic [1:0]      prev_priv_o,
    output logic [1:0]      priv_o,
    output logic            redir_o,
    output logic [XLEN-1:0] redir_pc_o
);
    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic            gie;
        logic            pgie;
        logic [1:0]      ppriv;
        logic [1:0]      priv;
        logic            redir;
        logic [XLEN-1:0] rpc;
    } state_t;

    state_t st_d, st_q;
    logic   take;

    assign take = trap_req_i & st_q.gie;

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        if (take) begin
            st_d.epc   = pc_i;
            st_d.cause = {trap_irq_i, trap_code_i};
            st_d.tval  = trap_val_i;
            st_d.ppriv = st_q.priv;
            st_d.pgie  = st_q.gie;
            st_d.gie   = 1'b0;
            st_d.priv  = PRIV_MACH;
            st_d.redir = 1'b1;
            st_d.rpc   = target_i;
        end else if (ld_i) begin
            st_d.gie  = ld_gie_i;
            st_d.priv = ld_priv_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.priv <= PRIV_MACH;
        end else begin
            st_q <= st_d;
        end
    end

    assign saved_pc_o  = st_q.epc;
    assign cause_o     = st_q.cause;
    assign tval_o      = st_q.tval;
    assign gie_o       = st_q.gie;
    assign prev_gie_o  = st_q.pgie;
    assign prev_priv_o = st_q.ppriv;
    assign priv_o      = st_q.priv;
    assign redir_o     = st_q.redir;
    assign redir_pc_o  = st_q.rpc;

    AST_REDIR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redir_o |=> !redir_o); // R10
    AST_GIE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redir_o |-> (!gie_o && prev_gie_o)); // R4
    AST_PRIV_MACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redir_o |-> (priv_o == PRIV_MACH)); // R5
    AST_IGNORED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_req_i && !gie_o && !ld_i) |=> (!redir_o && $stable(saved_pc_o)
            && $stable(cause_o) && $stable(tval_o))); // R9
    AST_TAKE_REDIRECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_req_i && gie_o) |=> (redir_o && saved_pc_o == $past(pc_i))); // R3
endmodule

// File: rtl/mtrap_entry.sv
module mtrap_entry
    import mtrap_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit VECTORED_EN = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            trap_req_i,
    input  logic            trap_irq_i,
    input  logic [XLEN-2:0] trap_code_i,
    input  logic [XLEN-1:0] trap_val_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] tvec_i,
    input  logic            ld_i,
    input  logic            ld_gie_i,
    input  logic [1:0]      ld_priv_i,
    output logic [XLEN-1:0] saved_pc_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] tval_o,
    output logic            gie_o,
    output logic            prev_gie_o,
    output logic [1:0]      prev_priv_o,
    output logic [1:0]      priv_o,
    output logic            redir_o,
    output logic [XLEN-1:0] redir_pc_o
);
    logic [XLEN-1:0] target;

    mtrap_target #(.XLEN(XLEN), .VECTORED_EN(VECTORED_EN)) i_target (
        .tvec_i   (tvec_i),
        .code_i   (trap_code_i),
        .target_o (target)
    );

    mtrap_regs #(.XLEN(XLEN)) i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trap_req_i  (trap_req_i),
        .trap_irq_i  (trap_irq_i),
        .trap_code_i (trap_code_i),
        .trap_val_i  (trap_val_i),
        .pc_i        (pc_i),
        .target_i    (target),
        .ld_i        (ld_i),
        .ld_gie_i    (ld_gie_i),
        .ld_priv_i   (ld_priv_i),
        .saved_pc_o  (saved_pc_o),
        .cause_o     (cause_o),
        .tval_o      (tval_o),
        .gie_o       (gie_o),
        .prev_gie_o  (prev_gie_o),
        .prev_priv_o (prev_priv_o),
        .priv_o      (priv_o),
        .redir_o     (redir_o),
        .redir_pc_o  (redir_pc_o)
    );

    AST_CAUSE_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_req_i && gie_o) |=> (cause_o == {$past(trap_irq_i), $past(trap_code_i)})); // R2
endmodule

// File: tb/test_mtrap_entry.sv
module test_mtrap_entry;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_req, trap_irq, ld, ld_gie;
    logic [30:0] trap_code;
    logic [31:0] trap_val, pc, tvec;
    logic [1:0]  ld_priv;
    logic [31:0] saved_pc, cause, tval, redir_pc;
    logic        gie, prev_gie, redir;
    logic [1:0]  prev_priv, priv;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mtrap_entry i_mtrap_entry (
        .clk_i(clk), .rst_ni(rst_n), .trap_req_i(trap_req), .trap_irq_i(trap_irq),
        .trap_code_i(trap_code), .trap_val_i(trap_val), .pc_i(pc), .tvec_i(tvec),
        .ld_i(ld), .ld_gie_i(ld_gie), .ld_priv_i(ld_priv),
        .saved_pc_o(saved_pc), .cause_o(cause), .tval_o(tval), .gie_o(gie),
        .prev_gie_o(prev_gie), .prev_priv_o(prev_priv), .priv_o(priv),
        .redir_o(redir), .redir_pc_o(redir_pc)
    );

    typedef struct packed {
        logic [31:0] tvec;
        logic [30:0] code;
        logic        irq;
        logic [31:0] pc;
        logic [31:0] val;
        logic [1:0]  priv;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h8000_0100, 31'd3,          1'b0, 32'h0000_1000, 32'h0000_DEAD, 2'b00}, // R6 direct
        '{32'h8000_0101, 31'd7,          1'b1, 32'h0000_2004, 32'h0000_0000, 2'b11}, // R7 vectored
        '{32'h8000_0102, 31'd11,         1'b0, 32'h0000_3008, 32'h1234_5678, 2'b01}, // R8 mode 2
        '{32'h8000_0103, 31'd5,          1'b1, 32'h0000_400C, 32'hFFFF_FFFF, 2'b00}, // R8 mode 3
        '{32'hFFFF_FFFD, 31'd2,          1'b0, 32'hFFFF_FFF0, 32'h0000_0001, 2'b01}, // R7 wrap
        '{32'h0000_0001, 31'h7FFF_FFFF,  1'b1, 32'h8000_0000, 32'hA5A5_A5A5, 2'b11}  // R7 big code
    };

    function automatic logic [31:0] exp_target(logic [31:0] tv, logic [30:0] c);
        logic [31:0] b;
        b = tv & 32'hFFFF_FFFC;
        if (tv[1:0] == 2'b01) return b + {c[29:0], 2'b00};
        return b;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic g, logic [1:0] p);
        @(negedge clk);
        ld = 1'b1; ld_gie = g; ld_priv = p;
        @(negedge clk);
        ld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; trap_irq = 1'b0; trap_code = '0;
        trap_val = '0; pc = '0; tvec = '0; ld = 1'b0; ld_gie = 1'b0; ld_priv = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 saved_pc", saved_pc, 0);
        chk("R1 cause", cause, 0);
        chk("R1 tval", tval, 0);
        chk("R1 gie", {31'd0, gie}, 0);
        chk("R1 prev_gie", {31'd0, prev_gie}, 0);
        chk("R1 prev_priv", {30'd0, prev_priv}, 0);
        chk("R1 priv", {30'd0, priv}, 3);
        chk("R1 redir", {31'd0, redir}, 0);

        // R11 load alone
        load(1'b1, 2'b01);
        chk("R11 gie loaded", {31'd0, gie}, 1);
        chk("R11 priv loaded", {30'd0, priv}, 1);

        for (int i = 0; i < NV; i++) begin
            load(1'b1, VECS[i].priv);
            trap_req = 1'b1; trap_irq = VECS[i].irq; trap_code = VECS[i].code;
            trap_val = VECS[i].val; pc = VECS[i].pc; tvec = VECS[i].tvec;
            @(negedge clk);
            trap_req = 1'b0;
            chk("R10 redir high", {31'd0, redir}, 1);
            chk("R6/R7/R8 redir_pc", redir_pc, exp_target(VECS[i].tvec, VECS[i].code));
            chk("R3 saved_pc", saved_pc, VECS[i].pc);
            chk("R2 cause", cause, {VECS[i].irq, VECS[i].code});
            chk("R5 tval", tval, VECS[i].val);
            chk("R5 priv", {30'd0, priv}, 3);
            chk("R4 prev_priv", {30'd0, prev_priv}, {30'd0, VECS[i].priv});
            chk("R4 prev_gie", {31'd0, prev_gie}, 1);
            chk("R4 gie cleared", {31'd0, gie}, 0);
            @(negedge clk);
            chk("R10 redir low", {31'd0, redir}, 0);
            chk("R10 redir_pc held", redir_pc, exp_target(VECS[i].tvec, VECS[i].code));
        end

        // R9: request with gie clear is ignored (gie is 0 after last trap)
        trap_req = 1'b1; trap_irq = 1'b0; trap_code = 31'd9;
        trap_val = 32'h1111_2222; pc = 32'h0000_7770; tvec = 32'h0000_0400;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R9 no redirect", {31'd0, redir}, 0);
        chk("R9 saved_pc kept", saved_pc, VECS[NV-1].pc);
        chk("R9 cause kept", cause, {VECS[NV-1].irq, VECS[NV-1].code});
        chk("R9 tval kept", tval, VECS[NV-1].val);
        chk("R9 priv kept", {30'd0, priv}, 3);
        chk("R9 prev_priv kept", {30'd0, prev_priv}, {30'd0, VECS[NV-1].priv});

        // R11: trap and load in the same cycle, trap wins
        load(1'b1, 2'b00);
        trap_req = 1'b1; ld = 1'b1; ld_gie = 1'b1; ld_priv = 2'b01;
        trap_irq = 1'b0; trap_code = 31'd4; trap_val = 32'h0; pc = 32'h0000_0ABC;
        tvec = 32'h0000_0200;
        @(negedge clk);
        trap_req = 1'b0; ld = 1'b0;
        chk("R11 trap wins gie", {31'd0, gie}, 0);
        chk("R11 trap wins priv", {30'd0, priv}, 3);
        chk("R11 prev_priv from before", {30'd0, prev_priv}, 0);
        chk("R11 redirect", {31'd0, redir}, 1);
        chk("R6 redir_pc", redir_pc, 32'h0000_0200);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule